// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host side of a read link to a serial data converter that returns 32-bit result frames. After a start request it drops chip select. It then watches the data line. While the line is high, the converter is still converting. Clocking begins only once the line reads low.

The reader produces an idle-low serial clock from the system clock through a programmable divider. It captures one bit on every rising edge, for 32 rising edges in all. It raises chip select half a serial period after the last rising edge. It then unpacks the frame into:
- a channel number,
- a signed 24-bit result,
- over-range and under-range flags,
- the five bits below the result's least significant bit.

A one-cycle valid pulse marks the new values. A programmable limit bounds the wait for the converter. In continuous mode a new read starts right after each valid pulse.

The controller has five states:
- **RD_IDLE**: chip select high. Leaves on start.
- **RD_POLL**: chip select low, serial clock low, waiting for the data line to read low.
- **RD_HIGH**: serial clock high.
- **RD_LOW**: serial clock low between bits.
- **RD_DONE**: one cycle, chip select high, valid.

The transitions are:
- IDLE→POLL on start.
- POLL→HIGH on a divider tick with the data line low; this is the first bit.
- POLL→IDLE on timeout.
- HIGH→LOW on a tick while fewer than 32 bits are held.
- HIGH→DONE on a tick after the 32nd bit.
- LOW→HIGH on a tick; this captures the next bit.
- DONE→POLL in continuous mode, DONE→IDLE otherwise.

Top module: `conv_frame_reader`

## Requirements
- R1: While reset is held, cs_n_o is 1, sclk_o is 0, valid_o is 0 and timeout_o is 0.
- R2: In idle, start_i lowers cs_n_o on the next cycle. sclk_o is high only while cs_n_o is low. No sclk_o rising edge occurs while the data line stays high in the polling state.
- R3: Clocking starts at a divider tick at which miso_i reads 0. Each sclk_o high and low phase lasts div_i+1 system clock cycles.
- R4: A frame consists of exactly 32 sclk_o rising edges. miso_i is captured on each rising edge. The first captured bit becomes frame bit 31 (end-of-conversion) and the last becomes frame bit 0.
- R5: cs_n_o rises div_i+1 cycles after the 32nd rising edge. valid_o is high for exactly that one cycle.
- R6: chan_o equals frame bit 30.
- R7: over_o is set when frame bits 29 and 28 are both 1. under_o is set when both are 0. The two flags are never high together.
- R8: When in range, result_o is {~bit29, bits 27..5}. When over_o is set, result_o is 24'h7FFFFF. When under_o is set, result_o is 24'h800000. sub_o always equals frame bits 4..0.
- R9: With a nonzero tmo_limit_i, the read is abandoned if miso_i stays high for tmo_limit_i+1 cycles of polling. On abandon, cs_n_o rises, timeout_o is set and the block returns to idle with no valid_o. A limit of 0 waits without bound. timeout_o clears on the next start.
- R10: If cont_i is high during valid_o, cs_n_o falls on the next cycle. If cont_i is low, the block stays idle until start_i. start_i has no effect while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request, honoured in idle only |
| cont_i | input | 1 | Continuous mode: restart after each frame |
| div_i | input | DIV_W | Serial clock half-period, in system cycles minus one |
| tmo_limit_i | input | TMO_W | Polling limit in system cycles; 0 disables the limit |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idle low |
| valid_o | output | 1 | One-cycle pulse when new results are available |
| chan_o | output | 1 | Reported channel |
| result_o | output | 24 | Signed result, saturated when out of range |
| over_o | output | 1 | Input above positive full scale |
| under_o | output | 1 | Input below negative full scale |
| sub_o | output | 5 | Bits below the result's LSB |
| timeout_o | output | 1 | Last read was abandoned while polling |

## Verification
Two events can fall in the same cycle:
- **Frame end and restart.** In continuous mode, frame completion and the start of the next read meet at the single DONE cycle. The bench runs back-to-back frames and checks that chip select is high for exactly the valid cycle and low on the one after.
- **End-of-conversion and timeout.** The end-of-conversion edge can race the timeout count. Both are provoked by setting the converter model's busy time against the limit: far beyond it, inside it, and with the limit disabled. In each case the bench judges whether a valid frame or a timeout results, and whether any serial clock edge appeared.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int FRAME_W  = 32;
    localparam int RES_W    = 24;
    localparam int SUB_W    = 5;
    localparam int B_CHAN   = 30;
    localparam int B_SIGN   = 29;
    localparam int B_TOP    = 28;
    localparam int B_RESLSB = 5;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_POLL,
        RD_HIGH,
        RD_LOW,
        RD_DONE
    } rd_state_t;

    typedef struct packed {
        logic             chan;
        logic             over;
        logic             under;
        logic [RES_W-1:0] result;
        logic [SUB_W-1:0] sub;
    } rd_word_t;
endpackage

// File: rtl/fr_tick_gen.sv
module fr_tick_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i || cnt_q >= div_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = run_i && (cnt_q >= div_i);

    // R3: after a tick with a nonzero divider the next cycle is never a tick
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && run_i && div_i != '0) |=> (!tick_o || $changed(div_i)));
endmodule

// File: rtl/fr_frame_decode.sv
module fr_frame_decode
    import fr_pkg::*;
(
    input  logic [FRAME_W-1:0] frame_i,
    output rd_word_t           word_o
);
    logic sign_b, top_b;

    always_comb begin
        sign_b       = frame_i[B_SIGN];
        top_b        = frame_i[B_TOP];
        word_o.chan  = frame_i[B_CHAN];
        word_o.over  = sign_b & top_b;
        word_o.under = ~sign_b & ~top_b;
        word_o.sub   = frame_i[SUB_W-1:0];
        unique case ({word_o.over, word_o.under})
            2'b10:   word_o.result = {1'b0, {(RES_W-1){1'b1}}};
            2'b01:   word_o.result = {1'b1, {(RES_W-1){1'b0}}};
            default: word_o.result = {~sign_b, frame_i[B_TOP-1:B_RESLSB]};
        endcase
    end
endmodule

// File: rtl/conv_frame_reader.sv
module conv_frame_reader
    import fr_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    cont_i,
    input  logic [DIV_W-1:0]        div_i,
    input  logic [TMO_W-1:0]        tmo_limit_i,
    input  logic                    miso_i,
    output logic                    cs_n_o,
    output logic                    sclk_o,
    output logic                    valid_o,
    output logic                    chan_o,
    output logic signed [RES_W-1:0] result_o,
    output logic                    over_o,
    output logic                    under_o,
    output logic [SUB_W-1:0]        sub_o,
    output logic                    timeout_o
);
    localparam int CNT_W = $clog2(FRAME_W + 1);

    rd_state_t          state_q, state_d;
    logic               tick;
    logic               run;
    logic [CNT_W-1:0]   bit_cnt_q;
    logic [FRAME_W-1:0] frame_q;
    logic [TMO_W-1:0]   wait_q;
    logic               capture;
    rd_word_t           word;

    assign run = (state_q == RD_POLL) || (state_q == RD_HIGH) || (state_q == RD_LOW);

    fr_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .div_i  (div_i),
        .tick_o (tick)
    );

    fr_frame_decode u_dec (
        .frame_i (frame_q),
        .word_o  (word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (start_i) state_d = RD_POLL;
            RD_POLL: begin
                if (tick && !miso_i)
                    state_d = RD_HIGH;
                else if (tmo_limit_i != '0 && wait_q == tmo_limit_i)
                    state_d = RD_IDLE;
            end
            RD_HIGH: if (tick) state_d = (bit_cnt_q == CNT_W'(FRAME_W)) ? RD_DONE : RD_LOW;
            RD_LOW:  if (tick) state_d = RD_HIGH;
            RD_DONE: state_d = cont_i ? RD_POLL : RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    assign capture = (state_d == RD_HIGH) && (state_q != RD_HIGH);

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            frame_q   <= '0;
            wait_q    <= '0;
            timeout_o <= 1'b0;
            chan_o    <= 1'b0;
            result_o  <= '0;
            over_o    <= 1'b0;
            under_o   <= 1'b0;
            sub_o     <= '0;
        end else begin
            if (state_q == RD_POLL) wait_q <= wait_q + 1'b1;
            else                    wait_q <= '0;

            if (state_q == RD_IDLE || state_q == RD_DONE) begin
                bit_cnt_q <= '0;
            end else if (capture) begin
                frame_q   <= {frame_q[FRAME_W-2:0], miso_i};
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (state_q == RD_POLL && state_d == RD_IDLE)
                timeout_o <= 1'b1;
            else if (state_q == RD_IDLE && start_i)
                timeout_o <= 1'b0;

            if (state_q == RD_HIGH && state_d == RD_DONE) begin
                chan_o   <= word.chan;
                result_o <= word.result;
                over_o   <= word.over;
                under_o  <= word.under;
                sub_o    <= word.sub;
            end
        end
    end

    assign cs_n_o  = (state_q == RD_IDLE) || (state_q == RD_DONE);
    assign sclk_o  = (state_q == RD_HIGH);
    assign valid_o = (state_q == RD_DONE);

    // R2: serial clock only toggles with the converter selected
    a_r2_sclk_selected: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);
    // R4: never more than a full frame of bits
    a_r4_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= CNT_W'(FRAME_W));
    // R5: valid comes with chip select released and lasts one cycle
    a_r5_valid_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && !sclk_o));
    a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);
    // R7: range flags exclusive
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_o && under_o));
    // R9: a timeout leaves the link deselected
    a_r9_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (cs_n_o && !valid_o));
    // R10: continuous mode reselects on the cycle after valid
    a_r10_cont_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cont_i) |=> !cs_n_o);
endmodule

// File: tb/sim_conv_frame_reader.sv
`timescale 1ns/1ps
module sim_conv_frame_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cont_i = 1'b0;
    logic [7:0]  div_i = 8'd0;
    logic [15:0] tmo_i = 16'd0;
    logic        miso;
    logic        cs_n_o, sclk_o, valid_o, chan_o, over_o, under_o, timeout_o;
    logic signed [23:0] result_o;
    logic [4:0]  sub_o;

    always #5 clk = ~clk;

    conv_frame_reader u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cont_i(cont_i),
        .div_i(div_i), .tmo_limit_i(tmo_i), .miso_i(miso),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .valid_o(valid_o), .chan_o(chan_o),
        .result_o(result_o), .over_o(over_o), .under_o(under_o),
        .sub_o(sub_o), .timeout_o(timeout_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // converter model
    int          idx = 0;
    int          rd_no = 0;
    int          busy_force = -1;
    int unsigned busy_lim = 0;
    int unsigned busy_cnt = 0;
    logic [31:0] cur_frame = 32'hFFFF_FFFF;
    int          rises = 0;
    time         t_rise = 0, t_cs = 0, hw = 0;

    function automatic logic [31:0] mk_frame(input int n);
        logic [27:0] body;
        body = 28'(n * 32'h02B5_C3A7) ^ 28'(n << 13) ^ 28'(n);
        return {1'b0, n[0], n[2], n[1], body};
    endfunction

    always @(negedge cs_n_o) begin
        rd_no++;
        idx = 0;
        rises = 0;
        cur_frame = mk_frame(rd_no);
        busy_lim = (busy_force >= 0) ? busy_force :
                   ((rd_no % 5 == 0) ? 0 : (rd_no * 7) % 23 + 2);
    end
    always @(negedge sclk_o) begin
        idx++;
        hw = $time - t_rise;
    end
    always @(posedge sclk_o) begin
        rises++;
        t_rise = $time;
    end
    always @(posedge cs_n_o) t_cs = $time;
    always @(posedge clk) begin
        if (cs_n_o) busy_cnt <= 0;
        else if (busy_cnt < 100000) busy_cnt <= busy_cnt + 1;
    end
    assign miso = cs_n_o ? 1'b1 : (busy_cnt < busy_lim) ? 1'b1 :
                  (idx < 32) ? cur_frame[31-idx] : 1'b1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (valid_o) begin got = 1'b1; break; end
        end
    endtask

    // checks at the negedge where valid_o is high
    task automatic check_read(input bit next_cs_low);
        logic [31:0] f;
        logic ov, un;
        logic [23:0] er;
        int half;
        f    = mk_frame(rd_no);
        ov   = f[29] & f[28];
        un   = ~f[29] & ~f[28];
        er   = ov ? 24'h7FFFFF : (un ? 24'h800000 : {~f[29], f[27:5]});
        half = (int'(div_i) + 1) * 10;
        chk(chan_o == f[30], "R6 chan", chan_o, f[30]);
        chk(over_o == ov, "R7 over", over_o, ov);
        chk(under_o == un, "R7 under", under_o, un);
        chk(result_o == er, "R8 result", result_o, er);
        chk(sub_o == f[4:0], "R8 sub", sub_o, f[4:0]);
        chk(rises == 32, "R4 rising edges", rises, 32);
        chk(cs_n_o == 1'b1, "R5 cs high at valid", cs_n_o, 1);
        chk(t_cs - t_rise == half, "R5 cs delay", t_cs - t_rise, half);
        chk(hw == half, "R3 half period", hw, half);
        @(negedge clk);
        chk(valid_o == 1'b0, "R5 valid width", valid_o, 0);
        chk(cs_n_o == !next_cs_low, "R10 cs after valid", cs_n_o, !next_cs_low);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    initial begin
        bit got;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n_o == 1'b1, "R1 cs", cs_n_o, 1);
        chk(sclk_o == 1'b0, "R1 sclk", sclk_o, 0);
        chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
        chk(timeout_o == 1'b0, "R1 timeout", timeout_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // sweep of dividers over all channel/range combinations (R3-R8)
        for (int d = 0; d < 3; d++) begin
            div_i = 8'(d);
            for (int k = 0; k < 16; k++) begin
                @(negedge clk) start_i = 1'b1;
                @(negedge clk) start_i = 1'b0;
                chk(cs_n_o == 1'b0, "R2 cs falls on start", cs_n_o, 0);
                wait_valid(got);
                chk(got, "R5 valid seen", got, 1);
                if (got) check_read(1'b0);
            end
        end

        // R9 timeout with the data line held busy
        div_i = 8'd1;
        tmo_i = 16'd20;
        busy_force = 1000;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(cs_n_o == 1'b0, "R9 still polling", cs_n_o, 0);
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R9 cs raised", cs_n_o, 1);
        chk(timeout_o == 1'b1, "R9 timeout flag", timeout_o, 1);
        chk(rises == 0, "R2 no sclk while busy", rises, 0);
        repeat (20) @(negedge clk);
        chk(cs_n_o == 1'b1, "R9 back to idle", cs_n_o, 1);

        // R9 limit 0 waits without bound; flag cleared on start
        tmo_i = 16'd0;
        busy_force = 150;
        pulse_start();
        chk(timeout_o == 1'b0, "R9 flag cleared", timeout_o, 1'b0);
        wait_valid(got);
        chk(got, "R9 unbounded wait completes", got, 1);
        if (got) check_read(1'b0);
        chk(timeout_o == 1'b0, "R9 no timeout", timeout_o, 0);

        // R9 busy ends inside the limit
        tmo_i = 16'd40;
        busy_force = 10;
        pulse_start();
        wait_valid(got);
        chk(got, "R9 early eoc completes", got, 1);
        if (got) check_read(1'b0);
        chk(timeout_o == 1'b0, "R9 no timeout early", timeout_o, 0);

        // R10 start ignored while busy
        busy_force = 5;
        pulse_start();
        repeat (40) @(negedge clk);
        pulse_start();
        wait_valid(got);
        chk(got, "R10 read with stray start", got, 1);
        if (got) check_read(1'b0);
        repeat (30) @(negedge clk);
        chk(cs_n_o == 1'b1, "R10 stray start ignored", cs_n_o, 1);

        // R10 continuous back-to-back reads
        busy_force = -1;
        div_i = 8'd0;
        cont_i = 1'b1;
        pulse_start();
        for (int r = 0; r < 4; r++) begin
            wait_valid(got);
            chk(got, "R10 continuous valid", got, 1);
            if (got) check_read(r < 3);
            if (r == 2) cont_i = 1'b0;
        end
        repeat (50) @(negedge clk);
        chk(cs_n_o == 1'b1, "R10 single mode stays idle", cs_n_o, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule